// File: doc/BRIEF.md
# Per-Channel Converter Gain and Offset Corrector

This block trims raw converter codes with a gain and an offset held for each channel. It serves two families of channels that share one pipeline: a sense family whose codes are 16 bits wide, and a drive family whose codes are 14 bits wide. Each request carries a family bit, a channel number and a code. The corrected code comes out two clock cycles later with the same family and channel tag beside it. The gain is an unsigned 16.16 fixed-point factor. The offset is a signed count of code steps. The result is rounded and then clamped to the legal code range of the family.

The gain and offset pairs are loaded through a simple write port, normally once after power-up. A read port returns any stored pair as a 48-bit image with the gain in the upper four bytes and the offset in the lower two. A single pulse on the bypass input makes every channel behave as gain one and offset zero until the next reset. The stored values stay untouched while bypass is active. A per-entry warning flag marks a stored pair that lies outside the expected trim range. Such a pair is still applied.

Top module: `corr_gainoff`

## Requirements
- R1: For a sense request (in_path=0), out_code = floor((code × gain + 32768) / 65536) + offset, evaluated with no loss of precision for any 16-bit code and any 32-bit gain. The 16.16 gain 0x00010000 means exactly 1.0, and halves round upward.
- R2: The offset is a 16-bit two's-complement number. It is added after the rounding step, in units of one output code.
- R3: A sense result is clamped to 0..0xFFFF. A drive request (in_path=1) uses only in_code[13:0], and its result is clamped to 0..0x3FFF, so out_code[15:14] is always 0 on that family.
- R4: A request with in_valid high at clock edge k produces out_valid high after edge k+2, with out_path and out_chan equal to the request's tag. Back-to-back requests are accepted on every cycle. out_valid is low when no request was taken two edges earlier.
- R5: Each of the 32 entries, indexed by {path, chan}, has its own gain and offset. A write with wr_en changes only the addressed entry, from the edge that samples it.
- R6: A byp_set pulse makes every request accepted on a later edge use gain 1.0 and offset 0, until reset. Stored pairs and readback are unaffected.
- R7: rd_req at edge k gives rd_valid high after edge k+1, with rd_data[47:16] = gain (byte 0 = gain bits 31..24 at rd_data[47:40]) and rd_data[15:0] = offset (high byte at rd_data[15:8]).
- R8: warn bit (path×16 + chan) is 1 when that entry's gain lies outside 0x0000F000..0x00011111 inclusive, or when its offset lies outside −15..+15. Writing an in-range pair clears the bit, and an out-of-range pair is still applied.
- R9: Synchronous reset sets every gain to 0x00010000 and every offset to 0, clears every warn bit and the bypass, and holds out_valid and rd_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Correction request strobe |
| in_path | input | 1 | 0 = sense family, 1 = drive family |
| in_chan | input | 4 | Request channel |
| in_code | input | 16 | Raw code |
| out_valid | output | 1 | Corrected result strobe |
| out_path | output | 1 | Family tag of the result |
| out_chan | output | 4 | Channel tag of the result |
| out_code | output | 16 | Corrected code |
| wr_en | input | 1 | Parameter write strobe |
| wr_path | input | 1 | Family of the written entry |
| wr_chan | input | 4 | Channel of the written entry |
| wr_gain | input | 32 | Gain, unsigned 16.16 |
| wr_ofs | input | 16 | Offset, signed |
| byp_set | input | 1 | Pulse that forces unity correction until reset |
| rd_req | input | 1 | Readback request |
| rd_path | input | 1 | Family of the entry to read |
| rd_chan | input | 4 | Channel of the entry to read |
| rd_valid | output | 1 | Readback data strobe |
| rd_data | output | 48 | Big-endian image {gain, offset} |
| warn | output | 32 | Per-entry out-of-range flags |

## Verification
Every one of the 32 entries is loaded with a distinct in-range pair and swept with the same eight codes. These cover zero, one, small odd values, the drive ceiling, mid-scale, full scale and two irregular values, so a swapped entry, a wrong family mask or a misplaced offset shows as a mismatch. The codes are streamed on consecutive cycles, which exposes latency or tag slips. Further runs use a gain of one half to separate round-half-up from truncation, and the largest gain with the largest offset to expose a narrowed product. A negative offset on zero input checks the lower clamp. Bypass, readback and reset are then shown apart by streaming through entries whose stored pair differs from unity.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef enum logic {
    PATH_SENSE = 1'b0,
    PATH_DRIVE = 1'b1
  } path_e;
endpackage

// File: rtl/corr_param_bank.sv
module corr_param_bank #(
  parameter int NENT   = 32,
  parameter int IDX_W  = 5,
  parameter int GAIN_W = 32,
  parameter int OFS_W  = 16,
  parameter logic [GAIN_W-1:0] UNITY   = 'h00010000,
  parameter logic [GAIN_W-1:0] GAIN_LO = 'h0000F000,
  parameter logic [GAIN_W-1:0] GAIN_HI = 'h00011111,
  parameter int OFS_LIM = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [GAIN_W-1:0] wr_gain,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [GAIN_W-1:0] a_gain,
  output logic [OFS_W-1:0]  a_ofs,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [GAIN_W-1:0] b_gain,
  output logic [OFS_W-1:0]  b_ofs,
  output logic [NENT-1:0]   warn
);
  localparam logic signed [OFS_W-1:0] OFS_HI = OFS_W'(OFS_LIM);
  localparam logic signed [OFS_W-1:0] OFS_LO = -OFS_HI;

  logic [GAIN_W-1:0] gain_q [NENT];
  logic [OFS_W-1:0]  ofs_q  [NENT];
  logic              wr_bad;

  always_comb begin
    wr_bad = (wr_gain < GAIN_LO) || (wr_gain > GAIN_HI) ||
             ($signed(wr_ofs) < OFS_LO) || ($signed(wr_ofs) > OFS_HI);
  end

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        gain_q[e] <= UNITY;
        ofs_q[e]  <= '0;
        warn[e]   <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        gain_q[e] <= wr_gain;
        ofs_q[e]  <= wr_ofs;
        warn[e]   <= wr_bad;
      end
    end
  end

  always_ff @(posedge clk) begin
    a_gain <= gain_q[a_idx];
    a_ofs  <= ofs_q[a_idx];
    b_gain <= gain_q[b_idx];
    b_ofs  <= ofs_q[b_idx];
  end
endmodule

// File: rtl/corr_arith.sv
module corr_arith
  import corr_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int OUT_W  = 14,
  parameter int GAIN_W = 32,
  parameter int OFS_W  = 16,
  parameter int FRAC   = 16
) (
  input  logic              path,
  input  logic [CODE_W-1:0] code,
  input  logic [GAIN_W-1:0] gain,
  input  logic [OFS_W-1:0]  ofs,
  output logic [CODE_W-1:0] res
);
  localparam int PROD_W = CODE_W + GAIN_W;
  localparam int RND_W  = PROD_W + 1;
  localparam int SHR_W  = RND_W - FRAC;
  localparam int SUM_W  = SHR_W + 2;
  localparam logic [RND_W-1:0] HALF = RND_W'(1) << (FRAC - 1);
  localparam logic signed [SUM_W-1:0] LIM_SENSE = SUM_W'((64'd1 << CODE_W) - 64'd1);
  localparam logic signed [SUM_W-1:0] LIM_DRIVE = SUM_W'((64'd1 << OUT_W) - 64'd1);

  logic [PROD_W-1:0]       prod;
  logic [RND_W-1:0]        rnd;
  logic [SHR_W-1:0]        shr;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] lim;

  always_comb begin
    prod = PROD_W'(code) * PROD_W'(gain);
    rnd  = RND_W'(prod) + HALF;
    shr  = rnd[RND_W-1:FRAC];
    sum  = $signed({2'b00, shr}) + SUM_W'($signed(ofs));
    lim  = (path_e'(path) == PATH_DRIVE) ? LIM_DRIVE : LIM_SENSE;
    if (sum[SUM_W-1])
      res = '0;
    else if (sum > lim)
      res = lim[CODE_W-1:0];
    else
      res = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/corr_gainoff.sv
module corr_gainoff
  import corr_pkg::*;
#(
  parameter int NCH     = 16,
  parameter int CODE_W  = 16,
  parameter int OUT_W   = 14,
  parameter int GAIN_W  = 32,
  parameter int OFS_W   = 16,
  parameter int FRAC    = 16,
  parameter logic [GAIN_W-1:0] GAIN_LO = 'h0000F000,
  parameter logic [GAIN_W-1:0] GAIN_HI = 'h00011111,
  parameter int OFS_LIM = 15,
  localparam int CH_W   = $clog2(NCH),
  localparam int NENT   = 2 * NCH,
  localparam int IDX_W  = CH_W + 1,
  localparam int IMG_W  = GAIN_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_path,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic              out_path,
  output logic [CH_W-1:0]   out_chan,
  output logic [CODE_W-1:0] out_code,
  input  logic              wr_en,
  input  logic              wr_path,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [GAIN_W-1:0] wr_gain,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic              byp_set,
  input  logic              rd_req,
  input  logic              rd_path,
  input  logic [CH_W-1:0]   rd_chan,
  output logic              rd_valid,
  output logic [IMG_W-1:0]  rd_data,
  output logic [NENT-1:0]   warn
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC;

  logic              byp_q;
  logic              s1_valid, s1_path, s1_byp;
  logic [CH_W-1:0]   s1_chan;
  logic [CODE_W-1:0] s1_code;
  logic [GAIN_W-1:0] bank_gain, use_gain, rb_gain;
  logic [OFS_W-1:0]  bank_ofs, use_ofs, rb_ofs;
  logic [CODE_W-1:0] s2_res;

  // Sticky bypass, cleared only by reset
  always_ff @(posedge clk) begin
    if (rst)          byp_q <= 1'b0;
    else if (byp_set) byp_q <= 1'b1;
  end

  corr_param_bank #(
    .NENT(NENT), .IDX_W(IDX_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W),
    .UNITY(UNITY), .GAIN_LO(GAIN_LO), .GAIN_HI(GAIN_HI), .OFS_LIM(OFS_LIM)
  ) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx({wr_path, wr_chan}),
    .wr_gain(wr_gain), .wr_ofs(wr_ofs),
    .a_idx({in_path, in_chan}), .a_gain(bank_gain), .a_ofs(bank_ofs),
    .b_idx({rd_path, rd_chan}), .b_gain(rb_gain), .b_ofs(rb_ofs),
    .warn(warn)
  );

  // Stage 1: tag, masked code and bypass state, aligned with the bank read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_path  <= 1'b0;
      s1_chan  <= '0;
      s1_code  <= '0;
      s1_byp   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_path  <= in_path;
      s1_chan  <= in_chan;
      s1_code  <= (path_e'(in_path) == PATH_DRIVE) ?
                  CODE_W'(in_code[OUT_W-1:0]) : in_code;
      s1_byp   <= byp_q;
    end
  end

  always_comb begin
    use_gain = s1_byp ? UNITY : bank_gain;
    use_ofs  = s1_byp ? '0    : bank_ofs;
  end

  corr_arith #(
    .CODE_W(CODE_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W), .FRAC(FRAC)
  ) u_arith (
    .path(s1_path), .code(s1_code), .gain(use_gain), .ofs(use_ofs), .res(s2_res)
  );

  // Stage 2: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_path  <= 1'b0;
      out_chan  <= '0;
      out_code  <= '0;
      rd_valid  <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_path  <= s1_path;
      out_chan  <= s1_chan;
      out_code  <= s2_res;
      rd_valid  <= rd_req;
    end
  end

  assign rd_data = {rb_gain, rb_ofs};
endmodule

// File: rtl/corr_gainoff_chk.sv
module corr_gainoff_chk #(
  parameter int CH_W   = 4,
  parameter int CODE_W = 16,
  parameter int OUT_W  = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_path,
  input logic [CH_W-1:0]   in_chan,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic              out_path,
  input logic [CH_W-1:0]   out_chan,
  input logic [CODE_W-1:0] out_code,
  input logic              byp_set,
  input logic              rd_req,
  input logic              rd_valid
);
  logic byp_seen;
  always_ff @(posedge clk) begin
    if (rst)          byp_seen <= 1'b0;
    else if (byp_set) byp_seen <= 1'b1;
  end

  assert_valid_lat_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  assert_idle_lat_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
  assert_tag_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 (out_chan == $past(in_chan, 2) && out_path == $past(in_path, 2)));
  assert_drive_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_path) |-> (out_code[CODE_W-1:OUT_W] == '0));
  assert_bypass_sense_R6: assert property (@(posedge clk) disable iff (rst)
    (byp_seen && in_valid && !in_path) |-> ##2 (out_code == $past(in_code, 2)));
  assert_bypass_drive_R6: assert property (@(posedge clk) disable iff (rst)
    (byp_seen && in_valid && in_path) |-> ##2
      (out_code[OUT_W-1:0] == $past(in_code[OUT_W-1:0], 2)));
  assert_rd_lat_R7: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  assert_rd_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !rd_valid));
endmodule

bind corr_gainoff corr_gainoff_chk #(.CH_W(CH_W), .CODE_W(CODE_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_path(in_path), .in_chan(in_chan),
  .in_code(in_code), .out_valid(out_valid), .out_path(out_path), .out_chan(out_chan),
  .out_code(out_code), .byp_set(byp_set), .rd_req(rd_req), .rd_valid(rd_valid)
);

// File: tb/tb_corr_gainoff.sv
`timescale 1ns/1ps
module tb_corr_gainoff;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_path = 1'b0;
  logic [3:0]  in_chan = '0;
  logic [15:0] in_code = '0;
  logic        out_valid, out_path;
  logic [3:0]  out_chan;
  logic [15:0] out_code;
  logic        wr_en = 1'b0, wr_path = 1'b0;
  logic [3:0]  wr_chan = '0;
  logic [31:0] wr_gain = '0;
  logic [15:0] wr_ofs = '0;
  logic        byp_set = 1'b0;
  logic        rd_req = 1'b0, rd_path = 1'b0;
  logic [3:0]  rd_chan = '0;
  logic        rd_valid;
  logic [47:0] rd_data;
  logic [31:0] warn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] codes [8] = '{16'h0000, 16'h0001, 16'h0005, 16'h3FFF,
                             16'h8000, 16'hFFFF, 16'h1234, 16'hC0DE};

  always #10 clk = ~clk;

  corr_gainoff dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_path(in_path), .in_chan(in_chan),
    .in_code(in_code), .out_valid(out_valid), .out_path(out_path), .out_chan(out_chan),
    .out_code(out_code), .wr_en(wr_en), .wr_path(wr_path), .wr_chan(wr_chan),
    .wr_gain(wr_gain), .wr_ofs(wr_ofs), .byp_set(byp_set), .rd_req(rd_req),
    .rd_path(rd_path), .rd_chan(rd_chan), .rd_valid(rd_valid), .rd_data(rd_data),
    .warn(warn)
  );

  function automatic logic [15:0] model(bit path, logic [15:0] code,
                                        logic [31:0] g, logic [15:0] o);
    longint c, p, r, s, mx;
    c  = path ? longint'(code & 16'h3FFF) : longint'(code);
    p  = c * longint'(g);
    r  = (p + 64'd32768) >> 16;
    s  = r + longint'($signed(o));
    mx = path ? 64'd16383 : 64'd65535;
    if (s < 0) s = 0;
    if (s > mx) s = mx;
    return 16'(s);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_param(bit p, int ch, logic [31:0] g, logic [15:0] o);
    @(negedge clk);
    wr_en = 1'b1; wr_path = p; wr_chan = 4'(ch); wr_gain = g; wr_ofs = o;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(bit p, int ch, logic [31:0] g, logic [15:0] o, string req);
    @(negedge clk);
    rd_req = 1'b1; rd_path = p; rd_chan = 4'(ch);
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid == 1'b1, req, "rd_valid", longint'(rd_valid), 1);
    chk(rd_data == {g, o}, req, "rd_data", longint'(rd_data), longint'({g, o}));
  endtask

  task automatic stream(bit p, int ch, logic [31:0] g, logic [15:0] o, string req);
    logic [15:0] expq [8];
    for (int k = 0; k < 8; k++) expq[k] = model(p, codes[k], g, o);
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      if (t >= 2) begin
        chk(out_valid == 1'b1, "R4", "out_valid", longint'(out_valid), 1);
        chk(out_path == p && out_chan == 4'(ch), "R4", "tag",
            longint'({out_path, out_chan}), longint'({p, 4'(ch)}));
        chk(out_code == expq[t-2], req, "out_code", longint'(out_code), longint'(expq[t-2]));
      end
      if (t < 8) begin
        in_valid = 1'b1; in_path = p; in_chan = 4'(ch); in_code = codes[t];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R4", "out_valid idle", longint'(out_valid), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] gain_of(int ch);
    return 32'h0000F000 + 32'(ch) * 32'h00000222;
  endfunction
  function automatic logic [15:0] ofs_of(bit p, int ch);
    return p ? 16'(7 - ch) : 16'(ch - 7);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: state after reset
    chk(out_valid == 1'b0, "R9", "out_valid", longint'(out_valid), 0);
    chk(warn == 32'h0, "R9", "warn", longint'(warn), 0);
    rd_check(1'b0, 9, 32'h00010000, 16'h0000, "R9");
    stream(1'b0, 9, 32'h00010000, 16'h0000, "R9");

    // R5: distinct in-range pair in every entry
    for (int p = 0; p < 2; p++)
      for (int ch = 0; ch < 16; ch++)
        wr_param(p[0], ch, gain_of(ch), ofs_of(p[0], ch));
    chk(warn == 32'h0, "R8", "warn in range", longint'(warn), 0);
    for (int p = 0; p < 2; p++)
      for (int ch = 0; ch < 16; ch++) begin
        rd_check(p[0], ch, gain_of(ch), ofs_of(p[0], ch), "R7");
        stream(p[0], ch, gain_of(ch), ofs_of(p[0], ch), p ? "R3" : "R5");
      end

    // R1: half gain separates rounding up from truncation
    wr_param(1'b0, 3, 32'h00008000, 16'h0000);
    chk(warn == 32'h00000008, "R8", "warn low gain", longint'(warn), 32'h8);
    stream(1'b0, 3, 32'h00008000, 16'h0000, "R1");
    // R1, R3: largest gain and offset, full-width product
    wr_param(1'b0, 3, 32'hFFFFFFFF, 16'h7FFF);
    stream(1'b0, 3, 32'hFFFFFFFF, 16'h7FFF, "R1");
    // R2, R3: negative offset and lower clamp; in-range pair clears warn (R8)
    wr_param(1'b0, 3, 32'h00010000, 16'hFFF1);
    chk(warn == 32'h0, "R8", "warn cleared", longint'(warn), 0);
    stream(1'b0, 3, 32'h00010000, 16'hFFF1, "R2");
    // R3: drive family upper clamp; offset 16 is outside the range (R8)
    wr_param(1'b1, 15, 32'h00020000, 16'h0010);
    chk(warn == 32'h80000000, "R8", "warn drive offset", longint'(warn), 32'h80000000);
    stream(1'b1, 15, 32'h00020000, 16'h0010, "R3");

    // R6: bypass forces unity everywhere, storage untouched
    @(negedge clk); byp_set = 1'b1;
    @(negedge clk); byp_set = 1'b0;
    stream(1'b0, 3, 32'h00010000, 16'h0000, "R6");
    stream(1'b1, 15, 32'h00010000, 16'h0000, "R6");
    stream(1'b1, 4, 32'h00010000, 16'h0000, "R6");
    rd_check(1'b1, 15, 32'h00020000, 16'h0010, "R6");
    chk(warn == 32'h80000000, "R6", "warn kept", longint'(warn), 32'h80000000);

    // R9: reset restores unity and clears bypass
    do_reset();
    @(negedge clk);
    chk(out_valid == 1'b0 && rd_valid == 1'b0, "R9", "valids",
        longint'({out_valid, rd_valid}), 0);
    chk(warn == 32'h0, "R9", "warn", longint'(warn), 0);
    rd_check(1'b1, 15, 32'h00010000, 16'h0000, "R9");
    stream(1'b1, 15, 32'h00010000, 16'h0000, "R9");
    wr_param(1'b1, 15, 32'h00008000, 16'h0003);
    stream(1'b1, 15, 32'h00008000, 16'h0003, "R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule